// File: doc/BRIEF.md
# Open-Drain Half-Duplex Line Arbiter

This block sits between a controller-side port and a card-side port that share one half-duplex, wired-AND serial line. The block sees each side as a sampled input level and drives each side only through a pull-low enable. There is no direction pin. Whichever side is first sampled low becomes the owner of the line. The block then copies the owner's low level onto the opposite side. Ownership ends only when both sides read high again. When the block stops pulling a side low, it raises a timed boost enable on that side, so that an active pull-up can charge the stray capacitance quickly.

One instance serves one channel, and a card slot normally uses three of them (data and two auxiliary lines). A sequencer drives the channel enable. While the enable is low, the card side is held low, the controller side is left released, and every input is ignored. After the enable rises again, the block waits until both sides read high before it arbitrates. Both inputs pass through a synchronizer before any decision is taken. The boost width is counted in system-clock cycles.

Top module: `line_arbiter`

## Requirements
- R1: With `chan_en` high and both lines high for at least 4 cycles, `host_pull_lo` and `card_pull_lo` are 0 and both boost outputs are 0.
- R2: From idle, a low on `host_in` asserts `card_pull_lo` at the third rising clock edge after the change (two synchronizer edges plus one decision edge), and not before.
- R3: From idle, a low on `card_in` alone makes the card side the owner and asserts `host_pull_lo` while the card side stays low.
- R4: If both inputs are first seen low in the same cycle, the host side becomes the owner: `card_pull_lo` = 1 and `host_pull_lo` = 0.
- R5: While one side owns the line, a low level on the other side never causes a pull on the owner's side.
- R6: When the owner releases, the copy stops, but the block stays owned until both sides read high. A low still present on the former non-owner side does not start a new ownership in the opposite direction.
- R7: When the block stops a copy pull on a side, it drives that side's boost output high for exactly `PULSE_CYC` consecutive cycles. A boost and a pull on the same side are never active together, and the owner side gets no boost.
- R8: While `chan_en` is low, `card_pull_lo` = 1, `host_pull_lo` = 0, both boosts are 0, and a low on `host_in` has no effect on any output.
- R9: After `chan_en` rises, no ownership starts until both synchronized lines read high, and releasing the card side on enable produces no boost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable from the activation sequencer |
| host_in | input | 1 | Sampled level of the controller-side line |
| card_in | input | 1 | Sampled level of the card-side line |
| host_pull_lo | output | 1 | Pull the controller-side line low |
| card_pull_lo | output | 1 | Pull the card-side line low |
| host_boost | output | 1 | Active pull-up enable, controller side |
| card_boost | output | 1 | Active pull-up enable, card side |

## Verification
A wrong owner shows at the ports three edges after the first falling input: the pull appears on the wrong side or is missing. If the block returns to idle too early, a lingering low on the former non-owner side produces a reverse pull within three cycles. If the block fails to leave the settle phase correctly after enable, a spurious `host_pull_lo` appears during the synchronizer delay. A miscounted boost shows as a pulse width other than `PULSE_CYC`, or as a pulse on the owner's side.

// File: rtl/line_arb_pkg.sv
package line_arb_pkg;

  typedef enum logic [1:0] {
    ARB_SETTLE = 2'd0,
    ARB_IDLE   = 2'd1,
    ARB_HOST   = 2'd2,
    ARB_CARD   = 2'd3
  } arb_state_e;

  // Fixed priority: the controller side wins a same-cycle tie.
  function automatic arb_state_e pick_owner(input logic h_lvl, input logic c_lvl);
    if (!h_lvl)      return ARB_HOST;
    else if (!c_lvl) return ARB_CARD;
    else             return ARB_IDLE;
  endfunction

  // Bits needed to hold the value n.
  function automatic int count_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int WIDTH     = 2,
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= {WIDTH{RESET_VAL}};
        end else if (s == 0) begin
          stage_q[s] <= d_async;
        end else begin
          stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/line_owner_fsm.sv
module line_owner_fsm
  import line_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic h_s,
  input  logic c_s,
  output logic drive_card_q,
  output logic drive_host_q
);

  arb_state_e state_q, state_d;
  logic       both_high;
  logic       drive_card_d, drive_host_d;

  assign both_high = h_s & c_s;

  always_comb begin
    state_d = state_q;
    if (!en) begin
      state_d = ARB_SETTLE;
    end else begin
      unique case (state_q)
        ARB_SETTLE: if (both_high) state_d = ARB_IDLE;
        ARB_IDLE:   state_d = pick_owner(h_s, c_s);
        ARB_HOST:   if (both_high) state_d = ARB_IDLE;
        ARB_CARD:   if (both_high) state_d = ARB_IDLE;
        default:    state_d = ARB_SETTLE;
      endcase
    end
  end

  assign drive_card_d = en & (state_d == ARB_HOST) & ~h_s;
  assign drive_host_d = en & (state_d == ARB_CARD) & ~c_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ARB_SETTLE;
      drive_card_q <= 1'b0;
      drive_host_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      drive_card_q <= drive_card_d;
      drive_host_q <= drive_host_d;
    end
  end

  // R4: tie goes to the host side
  p_host_priority_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == ARB_IDLE && !h_s && !c_s) |=> (state_q == ARB_HOST));

  // R5: ownership is kept while any side is still low
  p_owner_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == ARB_HOST && !both_high) |=> (state_q == ARB_HOST));

  p_owner_holds_card_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == ARB_CARD && !both_high) |=> (state_q == ARB_CARD));

  // R5: at most one side is copied at a time
  p_single_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drive_card_q, drive_host_q}));

  // R6: idle is entered only after both sides read high
  p_idle_after_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARB_IDLE && $past(state_q) != ARB_IDLE) |-> $past(both_high));

  // R8: disable forces the settle state and drops copies
  p_disable_settle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state_q == ARB_SETTLE && !drive_card_q && !drive_host_q));

  // R9: no owner straight out of settle
  p_settle_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARB_SETTLE) |=> (state_q == ARB_SETTLE || state_q == ARB_IDLE));

endmodule

// File: rtl/line_boost_timer.sv
module line_boost_timer
  import line_arb_pkg::*;
#(
  parameter int PULSE_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic drive_q,
  output logic boost
);

  localparam int CW = count_bits(PULSE_CYC);

  logic          drive_prev;
  logic          release_evt;
  logic [CW-1:0] cnt_q;

  assign release_evt = drive_prev & ~drive_q & en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_prev <= 1'b0;
      cnt_q      <= '0;
    end else begin
      drive_prev <= drive_q;
      if (!en || drive_q) begin
        cnt_q <= '0;
      end else if (release_evt) begin
        cnt_q <= CW'(PULSE_CYC);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign boost = (cnt_q != '0) & ~drive_q & en;

  // R7: a release always starts a pulse on the next cycle
  p_release_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (release_evt) |=> (boost || drive_q || !en));

  // R7: the counter never exceeds the programmed width
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(PULSE_CYC));

  // R8: disabled channel gives no boost
  p_no_boost_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));

endmodule

// File: rtl/line_arbiter.sv
module line_arbiter
  import line_arb_pkg::*;
#(
  parameter int PULSE_CYC   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic host_in,
  input  logic card_in,
  output logic host_pull_lo,
  output logic card_pull_lo,
  output logic host_boost,
  output logic card_boost
);

  localparam int SIDES = 2;   // index 0 = host, 1 = card

  logic [SIDES-1:0] lvl_sync;
  logic             h_s, c_s;
  logic             drive_card_q, drive_host_q;
  logic [SIDES-1:0] drive_vec;
  logic [SIDES-1:0] boost_vec;

  line_sync #(
    .WIDTH    (SIDES),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async({card_in, host_in}),
    .q_sync (lvl_sync)
  );

  assign h_s = lvl_sync[0];
  assign c_s = lvl_sync[1];

  line_owner_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (chan_en),
    .h_s         (h_s),
    .c_s         (c_s),
    .drive_card_q(drive_card_q),
    .drive_host_q(drive_host_q)
  );

  assign drive_vec = {drive_card_q, drive_host_q};

  generate
    for (genvar sd = 0; sd < SIDES; sd++) begin : g_boost
      line_boost_timer #(
        .PULSE_CYC(PULSE_CYC)
      ) u_boost (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (chan_en),
        .drive_q(drive_vec[sd]),
        .boost  (boost_vec[sd])
      );
    end
  endgenerate

  assign host_pull_lo = drive_host_q;
  assign card_pull_lo = ~chan_en | drive_card_q;
  assign host_boost   = boost_vec[0];
  assign card_boost   = boost_vec[1];

  // R7: a side is never pulled and boosted at once
  p_pull_boost_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_pull_lo && card_boost) && !(host_pull_lo && host_boost));

  // R5: the two sides are never pulled by copy at the same time
  p_no_cross_pull_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en |-> !(host_pull_lo && card_pull_lo));

  // R8: while disabled the controller side stays released
  p_host_free_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !host_pull_lo);

endmodule

// File: tb/line_arbiter_bench.sv
module line_arbiter_bench;

  localparam int PULSE = 10;
  localparam int HOLD  = 8;
  localparam int NVEC  = 13;

  // {host_ext, card_ext, exp_host_pull, exp_card_pull}
  localparam logic [3:0] VEC [NVEC] = '{
    4'b1100, 4'b0101, 4'b0001, 4'b1000, 4'b1100,
    4'b1010, 4'b0010, 4'b0100, 4'b1100, 4'b0101,
    4'b1100, 4'b1010, 4'b1100
  };

  logic clk = 1'b0;
  logic rst_n, en, h_ext, c_ext;
  logic host_pull_lo, card_pull_lo, host_boost, card_boost;
  wire  host_line = h_ext & ~host_pull_lo;
  wire  card_line = c_ext & ~card_pull_lo;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  line_arbiter #(.PULSE_CYC(PULSE)) u_line_arbiter (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_en     (en),
    .host_in     (host_line),
    .card_in     (card_line),
    .host_pull_lo(host_pull_lo),
    .card_pull_lo(card_pull_lo),
    .host_boost  (host_boost),
    .card_boost  (card_boost)
  );

  function automatic string vec_tag(input int i);
    case (i)
      0, 4, 8, 10, 12: return "R1";
      1, 9:            return "R2";
      2, 6:            return "R5";
      3, 7:            return "R6";
      default:         return "R3";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // counts boost cycles on one side and notes any boost on the other
  task automatic measure(input bit on_card, output int width, output bit other);
    width = 0;
    other = 1'b0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (on_card ? card_boost : host_boost) width++;
      if (on_card ? host_boost : card_boost) other = 1'b1;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int w;
    bit oth;
    bit seen;
    rst_n = 1'b0; en = 1'b0; h_ext = 1'b1; c_ext = 1'b1;
    settle(4);
    chk("R8", "reset host_pull_lo", host_pull_lo, 1'b0);
    chk("R8", "reset card_pull_lo", card_pull_lo, 1'b1);
    chk("R8", "reset boosts", host_boost | card_boost, 1'b0);
    rst_n = 1'b1;
    settle(2);
    en = 1'b1;
    settle(6);
    chk("R1", "idle host_pull_lo", host_pull_lo, 1'b0);
    chk("R1", "idle card_pull_lo", card_pull_lo, 1'b0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      {h_ext, c_ext} = VEC[i][3:2];
      settle(HOLD);
      chk(vec_tag(i), $sformatf("vec%0d host_pull_lo", i), host_pull_lo, VEC[i][1]);
      chk(vec_tag(i), $sformatf("vec%0d card_pull_lo", i), card_pull_lo, VEC[i][0]);
    end

    // R2 latency: change at negedge, result at third posedge
    h_ext = 1'b0;
    settle(1);
    chk("R2", "card_pull_lo after 1 edge", card_pull_lo, 1'b0);
    settle(1);
    chk("R2", "card_pull_lo after 2 edges", card_pull_lo, 1'b0);
    settle(1);
    chk("R2", "card_pull_lo after 3 edges", card_pull_lo, 1'b1);
    settle(HOLD);
    h_ext = 1'b1;
    measure(1'b1, w, oth);
    chk_int("R7", "card boost width", w, PULSE);
    chk("R7", "no boost on owner host side", oth, 1'b0);

    // R7 on the other direction
    c_ext = 1'b0;
    settle(HOLD);
    c_ext = 1'b1;
    measure(1'b0, w, oth);
    chk_int("R7", "host boost width", w, PULSE);
    chk("R7", "no boost on owner card side", oth, 1'b0);

    // R4 simultaneous fall
    h_ext = 1'b0; c_ext = 1'b0;
    settle(HOLD);
    chk("R4", "tie card_pull_lo", card_pull_lo, 1'b1);
    chk("R4", "tie host_pull_lo", host_pull_lo, 1'b0);
    h_ext = 1'b1; c_ext = 1'b1;
    settle(30);

    // R8 disabled: host low ignored
    en = 1'b0;
    h_ext = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (host_pull_lo || host_boost || card_boost || !card_pull_lo) seen = 1'b1;
    end
    chk("R8", "disabled outputs held", seen, 1'b0);
    h_ext = 1'b1;
    settle(4);

    // R9 re-enable: no owner, no boost during settle
    en = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (host_pull_lo || card_boost || host_boost) seen = 1'b1;
    end
    chk("R9", "no pull or boost after enable", seen, 1'b0);
    chk("R9", "card released after enable", card_pull_lo, 1'b0);
    c_ext = 1'b0;
    settle(HOLD);
    chk("R3", "card owner after enable", host_pull_lo, 1'b1);
    c_ext = 1'b1;
    settle(30);
    chk("R1", "final idle", host_pull_lo | card_pull_lo, 1'b0);

    finish_run();
  end

endmodule